// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block watches the byte stream of an arriving Ethernet frame and decides whether the frame should be kept. The first six bytes of the stream form the destination address. The filter compares that address with two programmable station addresses and with the all-ones broadcast address. It also looks the address up in a 64-entry single-hash table of joined group addresses. For each frame it gives one verdict, either keep or discard, together with the number of bytes to hand on when the frame is kept.

The frame arrives one byte per valid cycle. A start marker comes with the first byte and an end marker comes with the last byte. The station addresses, the hash table and the four receive-control enables are copied into the block on the start byte, so software can reprogram them while a frame is in flight. An early address-hit indication is available as soon as the destination is complete. The final verdict is issued one cycle after the end byte and takes the frame length into account.

Top module: `rx_dest_filter`

## Requirements
- R1: When rx_ctl bit 0 is set, a destination equal to station0 is a hit. Byte 0 of the destination, which is the first byte on the wire, is compared with bits [7:0], and byte 5 with bits [47:40].
- R2: When rx_ctl bit 1 is set, a destination equal to station1 is a hit, using the same byte order as R1.
- R3: When rx_ctl bit 3 is set, a destination of all ones is a hit.
- R4: The hash is formed as follows. Build the 48-bit string {byte5,...,byte0}, with byte 0 least significant and bit 0 of each byte first. Split it into eight 6-bit fields and XOR the fields together to get an index. An index below 32 selects that bit of grp_tbl_lo, and an index of 32 or more selects bit index-32 of grp_tbl_hi. When bit 0 of byte 0 is 1 (a group address), a set table bit is a hit.
- R5: An individual address (bit 0 of byte 0 equal to 0) is looked up in the hash table only while rx_ctl bit 2 is set.
- R6: addr_hit is 0 from the cycle after a start byte until the sixth byte has been taken. It shows the hit result in the cycle after the sixth byte, and it holds that value until the next start byte.
- R7: verdict_vld pulses for one cycle after each end byte. verdict_accept is 1 only if the address hit and the frame held at least 12 bytes, so a shorter frame is dropped even when its address matched.
- R8: pass_len is the frame length plus 4 for an accepted frame and 0 for a dropped frame.
- R9: The station addresses, the table and rx_ctl are sampled on the start byte. Changes made later in the same frame affect only later frames.
- R10: After reset, addr_hit, verdict_vld, verdict_accept and pass_len are 0. Valid bytes that arrive outside a frame (after an end byte and before the next start byte) are ignored, even if they carry an end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on in_data |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| station0 | input | 48 | Station address 0, byte 0 in bits [7:0] |
| station1 | input | 48 | Station address 1, byte 0 in bits [7:0] |
| grp_tbl_lo | input | 32 | Hash table entries 0 to 31 |
| grp_tbl_hi | input | 32 | Hash table entries 32 to 63 |
| rx_ctl | input | 4 | Enables: 0 = station0, 1 = station1, 2 = hash for individual addresses, 3 = broadcast |
| addr_hit | output | 1 | Early address-match result |
| verdict_vld | output | 1 | One-cycle pulse that marks a verdict |
| verdict_accept | output | 1 | Keep (1) or discard (0) for the last frame |
| pass_len | output | 17 | Bytes to pass on, including 4 CRC bytes, or 0 |

## Verification
Two things can happen in the same cycle. The verdict of a frame that has just ended is issued in the same cycle that the start byte of the next frame arrives, and on that start byte the new configuration is sampled and the captured destination is cleared. The bench sends two frames back to back with different rx_ctl settings. It checks the verdict of the first frame on the start cycle of the second, and it checks that the second frame is judged only by the settings it started with. A one-byte frame carries both markers on a single byte, which provokes start and finish on the same edge; it must give a plain drop.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Field order matches the rx_ctl port bit positions (bit 0 in the lsb).
  typedef struct packed {
    logic bcast;
    logic hash_indiv;
    logic st1;
    logic st0;
  } rx_ctl_t;

  localparam int CTL_W = $bits(rx_ctl_t);

endpackage

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 16,
  localparam int ADDR_W    = BYTE_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_data,
  output logic              start_o,
  output logic              last_o,
  output logic [LEN_W-1:0]  len_now_o,
  output logic [ADDR_W-1:0] dest_o,
  output logic              dest_done_o
);

  logic             in_frame_q, in_frame_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             take;
  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] len_now;

  // byte acceptance and position within the frame
  always_comb begin
    take    = in_valid && (in_sof || in_frame_q);
    pos     = in_sof ? '0 : cnt_q;
    if (in_sof)
      len_now = LEN_W'(1);
    else if (cnt_q == '1)
      len_now = cnt_q;
    else
      len_now = cnt_q + LEN_W'(1);
  end

  // next-state logic
  always_comb begin
    in_frame_d = in_frame_q;
    cnt_d      = cnt_q;
    done_d     = done_q;
    if (take) begin
      cnt_d = len_now;
      if (in_sof) begin
        in_frame_d = !in_eof;
        done_d     = 1'b0;
      end else if (in_eof) begin
        in_frame_d = 1'b0;
      end
      if (pos == LEN_W'(ADDR_BYTES - 1))
        done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
      done_q     <= done_d;
    end
  end

  // one byte lane per destination byte, each with its own write enable
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
    logic              lane_we;
    logic [BYTE_W-1:0] lane_q;
    assign lane_we = take && (pos == LEN_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (lane_we)
        lane_q <= in_data;
    end
    assign dest_o[k*BYTE_W +: BYTE_W] = lane_q;
  end

  assign start_o     = in_valid && in_sof;
  assign last_o      = take && in_eof;
  assign len_now_o   = len_now;
  assign dest_done_o = done_q;

endmodule

// File: rtl/rxf_cfg_latch.sv
module rxf_cfg_latch #(
  parameter int ADDR_W = 48,
  parameter int TBL_W  = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [ADDR_W-1:0]      st0_i,
  input  logic [ADDR_W-1:0]      st1_i,
  input  logic [TBL_W-1:0]       tbl_i,
  input  rxf_pkg::rx_ctl_t       ctl_i,
  output logic [ADDR_W-1:0]      st0_o,
  output logic [ADDR_W-1:0]      st1_o,
  output logic [TBL_W-1:0]       tbl_o,
  output rxf_pkg::rx_ctl_t       ctl_o
);

  logic [ADDR_W-1:0] st0_q, st1_q;
  logic [TBL_W-1:0]  tbl_q;
  rxf_pkg::rx_ctl_t  ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0_q <= '0;
      st1_q <= '0;
      tbl_q <= '0;
      ctl_q <= '0;
    end else if (load_i) begin
      st0_q <= st0_i;
      st1_q <= st1_i;
      tbl_q <= tbl_i;
      ctl_q <= ctl_i;
    end
  end

  assign st0_o = st0_q;
  assign st1_o = st1_q;
  assign tbl_o = tbl_q;
  assign ctl_o = ctl_q;

endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int ADDR_W  = 48,
  parameter int HASH_W  = 6,
  localparam int TBL_W  = 1 << HASH_W,
  localparam int FIELDS = ADDR_W / HASH_W
) (
  input  logic [ADDR_W-1:0]  dest_i,
  input  logic [ADDR_W-1:0]  st0_i,
  input  logic [ADDR_W-1:0]  st1_i,
  input  logic [TBL_W-1:0]   tbl_i,
  input  rxf_pkg::rx_ctl_t   ctl_i,
  output logic               hit_o
);

  logic [HASH_W-1:0] idx;
  logic              is_group;
  logic              hash_en;
  logic              hit_st0, hit_st1, hit_bc, hit_hash;

  // fold the destination into one index, field by field
  always_comb begin
    idx = '0;
    for (int f = 0; f < FIELDS; f++)
      idx = idx ^ dest_i[f*HASH_W +: HASH_W];
  end

  always_comb begin
    is_group = dest_i[0];
    hash_en  = is_group || ctl_i.hash_indiv;
    hit_st0  = ctl_i.st0   && (dest_i == st0_i);
    hit_st1  = ctl_i.st1   && (dest_i == st1_i);
    hit_bc   = ctl_i.bcast && (&dest_i);
    hit_hash = hash_en     && tbl_i[idx];
    hit_o    = hit_st0 || hit_st1 || hit_bc || hit_hash;
  end

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict #(
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 12,
  parameter int CRC_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             hit_i,
  output logic             vld_o,
  output logic             accept_o,
  output logic [LEN_W:0]   pass_len_o
);

  logic           vld_q, vld_d;
  logic           acc_q, acc_d;
  logic [LEN_W:0] plen_q, plen_d;
  logic           long_enough;

  always_comb begin
    long_enough = (len_i >= LEN_W'(MIN_LEN));
    vld_d       = last_i;
    acc_d       = acc_q;
    plen_d      = plen_q;
    if (last_i) begin
      acc_d  = hit_i && long_enough;
      plen_d = acc_d ? ({1'b0, len_i} + (LEN_W+1)'(CRC_BYTES)) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      acc_q  <= 1'b0;
      plen_q <= '0;
    end else begin
      vld_q  <= vld_d;
      acc_q  <= acc_d;
      plen_q <= plen_d;
    end
  end

  assign vld_o      = vld_q;
  assign accept_o   = acc_q;
  assign pass_len_o = plen_q;

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 12,
  parameter int CRC_BYTES  = 4,
  localparam int ADDR_W    = BYTE_W * ADDR_BYTES,
  localparam int TBL_W     = 1 << HASH_W,
  localparam int HALF_W    = TBL_W / 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_sof,
  input  logic                       in_eof,
  input  logic [BYTE_W-1:0]          in_data,
  input  logic [ADDR_W-1:0]          station0,
  input  logic [ADDR_W-1:0]          station1,
  input  logic [HALF_W-1:0]          grp_tbl_lo,
  input  logic [HALF_W-1:0]          grp_tbl_hi,
  input  logic [rxf_pkg::CTL_W-1:0]  rx_ctl,
  output logic                       addr_hit,
  output logic                       verdict_vld,
  output logic                       verdict_accept,
  output logic [LEN_W:0]             pass_len
);

  logic              start, last, dest_done, hit;
  logic [LEN_W-1:0]  len_now;
  logic [ADDR_W-1:0] dest, st0_s, st1_s;
  logic [TBL_W-1:0]  tbl_s;
  rxf_pkg::rx_ctl_t  ctl_s;

  rxf_dest_capture #(
    .BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .start_o(start), .last_o(last), .len_now_o(len_now),
    .dest_o(dest), .dest_done_o(dest_done)
  );

  rxf_cfg_latch #(.ADDR_W(ADDR_W), .TBL_W(TBL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(start),
    .st0_i(station0), .st1_i(station1),
    .tbl_i({grp_tbl_hi, grp_tbl_lo}),
    .ctl_i(rxf_pkg::rx_ctl_t'(rx_ctl)),
    .st0_o(st0_s), .st1_o(st1_s), .tbl_o(tbl_s), .ctl_o(ctl_s)
  );

  rxf_match #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_match (
    .dest_i(dest), .st0_i(st0_s), .st1_i(st1_s), .tbl_i(tbl_s),
    .ctl_i(ctl_s), .hit_o(hit)
  );

  assign addr_hit = dest_done && hit;

  rxf_verdict #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .CRC_BYTES(CRC_BYTES)
  ) u_verdict (
    .clk(clk), .rst_n(rst_n), .last_i(last), .len_i(len_now), .hit_i(addr_hit),
    .vld_o(verdict_vld), .accept_o(verdict_accept), .pass_len_o(pass_len)
  );

endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 12,
  parameter int CRC_BYTES  = 4,
  localparam int ADDR_W    = BYTE_W * ADDR_BYTES,
  localparam int TBL_W     = 1 << HASH_W,
  localparam int HALF_W    = TBL_W / 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_sof,
  input logic                       in_eof,
  input logic [BYTE_W-1:0]          in_data,
  input logic [ADDR_W-1:0]          station0,
  input logic [ADDR_W-1:0]          station1,
  input logic [HALF_W-1:0]          grp_tbl_lo,
  input logic [HALF_W-1:0]          grp_tbl_hi,
  input logic [rxf_pkg::CTL_W-1:0]  rx_ctl,
  input logic                       addr_hit,
  input logic                       verdict_vld,
  input logic                       verdict_accept,
  input logic [LEN_W:0]             pass_len
);

  a_r6_hit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && !(in_valid && in_sof)) |=> addr_hit);

  a_r6_hit_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !addr_hit);

  a_r7_vld_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $past(in_valid && in_eof));

  a_r7_accept_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && verdict_accept) |-> $past(addr_hit));

  a_r8_zero_len_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && !verdict_accept) |-> (pass_len == '0));

  a_r8_min_len_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && verdict_accept) |-> (int'(pass_len) >= MIN_LEN + CRC_BYTES));

endmodule

bind rx_dest_filter rx_dest_filter_chk #(
  .BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W),
  .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .CRC_BYTES(CRC_BYTES)
) u_chk (.*);

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;

  localparam logic [47:0] ST0   = 48'h665544332210;
  localparam logic [47:0] ST1   = 48'h0B0A09080706;
  localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] GA_LO = 48'h000000000001; // index 1 -> lo bit 1
  localparam logic [47:0] GA_HI = 48'h800000000001; // index 33 -> hi bit 1
  localparam logic [47:0] GA_MS = 48'h000000000101; // index 5 -> clear
  localparam logic [47:0] IND_H = 48'h000000000040; // individual, index 1
  localparam int NV = 14;

  // {ctl[61:58], len[57:50], dest[49:2], exp_hit[1], exp_acc[0]}
  localparam logic [61:0] VEC [NV] = '{
    {4'b0001, 8'd20, ST0,   1'b1, 1'b1},  // R1 keep
    {4'b0000, 8'd20, ST0,   1'b0, 1'b0},  // R1 disabled
    {4'b0010, 8'd14, ST1,   1'b1, 1'b1},  // R2 keep
    {4'b0001, 8'd14, ST1,   1'b0, 1'b0},  // R2 wrong enable
    {4'b1000, 8'd64, BCAST, 1'b1, 1'b1},  // R3 keep
    {4'b0000, 8'd64, BCAST, 1'b0, 1'b0},  // R3 disabled
    {4'b0000, 8'd12, GA_LO, 1'b1, 1'b1},  // R4 low word, 12 bytes
    {4'b0000, 8'd30, GA_HI, 1'b1, 1'b1},  // R4 high word
    {4'b0000, 8'd30, GA_MS, 1'b0, 1'b0},  // R4 clear bit
    {4'b0000, 8'd30, IND_H, 1'b0, 1'b0},  // R5 hash off for individual
    {4'b0100, 8'd30, IND_H, 1'b1, 1'b1},  // R5 hash on for individual
    {4'b0001, 8'd11, ST0,   1'b1, 1'b0},  // R7 short frame
    {4'b0001, 8'd5,  ST0,   1'b1, 1'b0},  // R7 dest incomplete
    {4'b0011, 8'd12, ST1,   1'b1, 1'b1}   // R2 both enables
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic [47:0] station0, station1;
  logic [31:0] grp_tbl_lo, grp_tbl_hi;
  logic [3:0]  rx_ctl;
  logic        addr_hit, verdict_vld, verdict_accept;
  logic [16:0] pass_len;

  int nchk = 0;
  int nerr = 0;

  rx_dest_filter i_rx_dest_filter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .station0(station0), .station1(station1),
    .grp_tbl_lo(grp_tbl_lo), .grp_tbl_hi(grp_tbl_hi), .rx_ctl(rx_ctl),
    .addr_hit(addr_hit), .verdict_vld(verdict_vld),
    .verdict_accept(verdict_accept), .pass_len(pass_len)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    in_data  = 8'h00;
  endtask

  // Drives one frame, one byte per cycle. When pv is set, the verdict of
  // the previous frame is checked on the start cycle of this one.
  task automatic frame_bytes(input logic [47:0] dest, input int len,
                             input logic exp_hit, input logic [3:0] ctl,
                             input logic flip, input logic pv,
                             input logic pv_acc, input int pv_len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pv && i == 0) begin
        chk("R7 back-to-back verdict pulse", 32'(verdict_vld), 32'd1);
        chk("R7 back-to-back accept", 32'(verdict_accept), 32'(pv_acc));
        chk("R8 back-to-back length", 32'(pass_len), pv_acc ? 32'(pv_len + 4) : 32'd0);
      end
      if (i == 5) chk("R6 addr_hit low before dest", 32'(addr_hit), 32'd0);
      if (i == 6) chk("R6 addr_hit after sixth byte", 32'(addr_hit), 32'(exp_hit));
      if (i == 0) rx_ctl = ctl;
      if (flip && i == 3) begin
        rx_ctl   = 4'b0000;
        station0 = ~station0;
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = (i < 6) ? dest[i*8 +: 8] : 8'(8'hA0 + i);
    end
  endtask

  task automatic verdict_chk(input string tag, input int len,
                             input logic exp_hit, input logic exp_acc);
    @(negedge clk);
    chk({tag, " verdict pulse"}, 32'(verdict_vld), 32'd1);
    chk({tag, " accept"}, 32'(verdict_accept), 32'(exp_acc));
    chk({"R8 ", tag, " pass_len"}, 32'(pass_len), exp_acc ? 32'(len + 4) : 32'd0);
    chk({"R6 ", tag, " hit held"}, 32'(addr_hit), (len >= 6) ? 32'(exp_hit) : 32'd0);
    idle();
    @(negedge clk);
    chk({"R7 ", tag, " pulse ends"}, 32'(verdict_vld), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL R7 watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    idle();
    station0   = ST0;
    station1   = ST1;
    grp_tbl_lo = 32'h0000_0002;
    grp_tbl_hi = 32'h0000_0002;
    rx_ctl     = 4'b0000;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset addr_hit", 32'(addr_hit), 32'd0);
    chk("R10 reset verdict_vld", 32'(verdict_vld), 32'd0);
    chk("R10 reset accept", 32'(verdict_accept), 32'd0);
    chk("R10 reset pass_len", 32'(pass_len), 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      frame_bytes(VEC[v][49:2], int'(VEC[v][57:50]), VEC[v][1], VEC[v][61:58],
                  1'b0, 1'b0, 1'b0, 0);
      verdict_chk($sformatf("R1-R5 vec%0d", v), int'(VEC[v][57:50]), VEC[v][1], VEC[v][0]);
    end

    // R9: settings changed mid-frame must not affect this frame
    frame_bytes(ST0, 16, 1'b1, 4'b0001, 1'b1, 1'b0, 1'b0, 0);
    verdict_chk("R9 mid-frame change", 16, 1'b1, 1'b1);
    station0 = ST0;

    // R10: stray bytes outside a frame, including an end marker
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (i > 0) chk("R10 stray no verdict", 32'(verdict_vld), 32'd0);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_eof   = (i == 2);
      in_data  = 8'hFF;
    end
    @(negedge clk);
    chk("R10 stray end ignored", 32'(verdict_vld), 32'd0);
    chk("R10 stray addr_hit held", 32'(addr_hit), 32'd1);
    chk("R10 stray pass_len held", 32'(pass_len), 32'd20);
    idle();

    // R9 second part: a later frame uses the new setting
    frame_bytes(ST0, 16, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 0);
    verdict_chk("R9 later frame", 16, 1'b0, 1'b0);

    // back to back: verdict of frame A on the start cycle of frame B
    frame_bytes(ST1, 12, 1'b1, 4'b0010, 1'b0, 1'b0, 1'b0, 0);
    frame_bytes(ST1, 13, 1'b0, 4'b0001, 1'b0, 1'b1, 1'b1, 12);
    verdict_chk("R9 frame B own settings", 13, 1'b0, 1'b0);

    // one-byte frame: start and end on the same byte
    frame_bytes(ST0, 1, 1'b0, 4'b0001, 1'b0, 1'b0, 1'b0, 0);
    verdict_chk("R7 one-byte frame", 1, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule